// File: doc/BRIEF.md
# Multi-Waveform Sample Generator

This block produces a stream of 8-bit samples for an external parallel DAC. It can make one of four periodic shapes: square, ramp, triangle and sine. The shape is picked by a 2-bit select input. A programmable divider derives a sample-advance tick from the system clock, and its 24-bit terminal count may be rewritten at any moment. The tick rate alone therefore sets the output frequency.

Each shape is built at full swing by its own next-sample rule. The square toggles. The ramp counts and wraps. The triangle counts up and down under a direction bit. The sine steps a 10-bit phase through a 32-entry constant table. An 8-bit amplitude code then scales the full-swing sample, and the result is registered onto the DAC port. A change of shape restarts the new shape from its zero state, so the output starts clean.

Top module: `multiwave_gen`

## Requirements
- R1: While rst_ni is low, dac_o is 0. After release, every shape starts from a raw sample of 0; the sine starts from phase 0.
- R2: With limit L = div_limit_i, the raw sample advances exactly once every max(L,1)+1 clocks. A limit of 0 behaves like a limit of 1. After reset release, the n-th advance happens on clock edge n·(max(L,1)+1).
- R3: If the limit is lowered to a value at or below the current count, the divider fires on the very next clock edge and then restarts from zero.
- R4: wave_sel_i = 0 selects square. On each tick, a raw sample of 0 becomes 255 and any other value becomes 0.
- R5: wave_sel_i = 1 selects ramp. On each tick the raw sample goes up by 1, and 255 is followed by 0.
- R6: wave_sel_i = 2 selects triangle. The raw sample goes up by 1 per tick until it reaches 255, then down by 1 per tick until it reaches 0, then up again. Each extreme is emitted once.
- R7: wave_sel_i = 3 selects sine. Each tick adds 32 to a 10-bit phase. The raw sample is 128 + round(127·sin(2πk/32)), where k = phase[9:5].
- R8: dac_o equals (raw · amp_i) >> 8, registered one clock after the raw sample or amp_i changes. An amp_i of 0 forces dac_o to 0.
- R9: When wave_sel_i differs from the active shape, the next clock edge makes the new shape active. That same edge clears the raw sample, the phase and the direction bit (direction set to up), and no tick is applied on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wave_sel_i | input | 2 | Shape select: 0 square, 1 ramp, 2 triangle, 3 sine |
| div_limit_i | input | 24 | Divider terminal count; 0 is treated as 1 |
| amp_i | input | 8 | Amplitude code; full-swing sample scaled by amp_i/256 |
| dac_o | output | 8 | Registered, scaled DAC word |

## Verification
A corrupted divider count shows up as a sample advance that comes too early or too late. The bench catches this at the first tick, because every sample is taken on its exact predicted edge. A wrong ramp, triangle or sine step, or a lost direction bit, shows up as a wrong DAC word one clock after the offending tick. A triangle stuck at an extreme shows up within two ticks of 255 or 0. A shape switch that does not clear state shows up as a nonzero word two clocks after the select changes.

// File: rtl/mwg_pkg.sv
package mwg_pkg;
  localparam int SAMPLE_W   = 8;
  localparam int PHASE_W    = 10;
  localparam int PHASE_STEP = 32;
  localparam int LUT_AW     = PHASE_W - $clog2(PHASE_STEP);

  typedef enum logic [1:0] {
    WAVE_SQUARE = 2'd0,
    WAVE_RAMP   = 2'd1,
    WAVE_TRI    = 2'd2,
    WAVE_SINE   = 2'd3
  } wave_e;

  typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/mwg_tick_div.sv
module mwg_tick_div #(
  parameter int DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] limit_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim_eff;

  assign lim_eff = (limit_i == '0) ? DIV_W'(1) : limit_i;
  // >= so a live drop of the limit below the count fires at once
  assign tick_o  = (cnt_q >= lim_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/mwg_sine_lut.sv
module mwg_sine_lut
  import mwg_pkg::*;
(
  input  logic [LUT_AW-1:0] idx_i,
  output sample_t           sample_o
);
  localparam int QTR = 2 ** (LUT_AW - 2);

  logic [LUT_AW-3:0] pos;
  logic [LUT_AW-2:0] qi;
  logic [6:0]        mag;

  // quarter-wave magnitudes, round(127*sin(2*pi*i/32)), i = 0..8
  function automatic logic [6:0] qtr_mag(input logic [LUT_AW-2:0] i);
    case (i)
      4'd0:    return 7'd0;
      4'd1:    return 7'd25;
      4'd2:    return 7'd49;
      4'd3:    return 7'd71;
      4'd4:    return 7'd90;
      4'd5:    return 7'd106;
      4'd6:    return 7'd117;
      4'd7:    return 7'd125;
      default: return 7'd127;
    endcase
  endfunction

  assign pos = idx_i[LUT_AW-3:0];
  // falling quarters mirror the index
  assign qi  = idx_i[LUT_AW-2] ? ((LUT_AW-1)'(QTR) - {1'b0, pos}) : {1'b0, pos};
  assign mag = qtr_mag(qi);
  assign sample_o = idx_i[LUT_AW-1] ? (8'd128 - {1'b0, mag}) : (8'd128 + {1'b0, mag});
endmodule

// File: rtl/mwg_wave_core.sv
module mwg_wave_core
  import mwg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  wave_e   sel_i,
  input  logic    tick_i,
  output sample_t raw_o
);
  wave_e              wave_q;
  sample_t            smp_q, smp_d;
  logic               dir_up_q, dir_up_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               sel_chg;
  sample_t            sine_smp;

  assign sel_chg = (sel_i != wave_q);

  mwg_sine_lut i_lut (
    .idx_i    (phase_q[PHASE_W-1 -: LUT_AW]),
    .sample_o (sine_smp)
  );

  always_comb begin
    smp_d    = smp_q;
    dir_up_d = dir_up_q;
    phase_d  = phase_q;
    if (tick_i) begin
      unique case (wave_q)
        WAVE_SQUARE: smp_d = (smp_q == '0) ? '1 : '0;
        WAVE_RAMP:   smp_d = (smp_q != '1) ? smp_q + 1'b1 : '0;
        WAVE_TRI: begin
          if (dir_up_q) begin
            if (smp_q == '1) begin
              dir_up_d = 1'b0;
              smp_d    = smp_q - 1'b1;
            end else begin
              smp_d    = smp_q + 1'b1;
            end
          end else begin
            if (smp_q == '0) begin
              dir_up_d = 1'b1;
              smp_d    = smp_q + 1'b1;
            end else begin
              smp_d    = smp_q - 1'b1;
            end
          end
        end
        WAVE_SINE:   phase_d = phase_q + PHASE_W'(PHASE_STEP);
        default:     smp_d = smp_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q   <= WAVE_SQUARE;
      smp_q    <= '0;
      dir_up_q <= 1'b1;
      phase_q  <= '0;
    end else if (sel_chg) begin
      wave_q   <= sel_i;
      smp_q    <= '0;
      dir_up_q <= 1'b1;
      phase_q  <= '0;
    end else begin
      smp_q    <= smp_d;
      dir_up_q <= dir_up_d;
      phase_q  <= phase_d;
    end
  end

  assign raw_o = (wave_q == WAVE_SINE) ? sine_smp : smp_q;

  p_square_levels_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_q == WAVE_SQUARE) |-> (smp_q == '0 || smp_q == '1));
  p_ramp_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_q == WAVE_RAMP && tick_i && !sel_chg) |=> (smp_q == $past(smp_q) + 8'd1));
  p_tri_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_q == WAVE_TRI && !sel_chg) |=>
      (smp_q == $past(smp_q) + 8'd1 || smp_q == $past(smp_q) - 8'd1 || smp_q == $past(smp_q)));
  p_phase_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q[$clog2(PHASE_STEP)-1:0] == '0);
  p_sel_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg |=> (smp_q == '0 && phase_q == '0 && dir_up_q));
endmodule

// File: rtl/mwg_amp_scale.sv
module mwg_amp_scale
  import mwg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  sample_t raw_i,
  input  sample_t amp_i,
  output sample_t dac_o
);
  logic [2*SAMPLE_W-1:0] prod;

  assign prod = raw_i * amp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dac_o <= '0;
    else         dac_o <= prod[2*SAMPLE_W-1:SAMPLE_W];
  end

  p_zero_amp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_i == '0) |=> (dac_o == '0));
  p_below_raw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (dac_o <= $past(raw_i)));
endmodule

// File: rtl/multiwave_gen.sv
module multiwave_gen
  import mwg_pkg::*;
#(
  parameter int DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       wave_sel_i,
  input  logic [DIV_W-1:0] div_limit_i,
  input  logic [7:0]       amp_i,
  output logic [7:0]       dac_o
);
  logic    tick;
  sample_t raw;

  mwg_tick_div #(.DIV_W(DIV_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .limit_i (div_limit_i),
    .tick_o  (tick)
  );

  mwg_wave_core i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (wave_e'(wave_sel_i)),
    .tick_i (tick),
    .raw_o  (raw)
  );

  mwg_amp_scale i_scale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw),
    .amp_i  (amp_i),
    .dac_o  (dac_o)
  );

  p_reset_out_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (dac_o == 8'd0));
endmodule

// File: tb/test_multiwave_gen.sv
`timescale 1ns/1ps
module test_multiwave_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  wave_sel = 2'd0;
  logic [23:0] div_limit = 24'd1;
  logic [7:0]  amp = 8'd128;
  logic [7:0]  dac;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  multiwave_gen i_multiwave_gen (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wave_sel_i  (wave_sel),
    .div_limit_i (div_limit),
    .amp_i       (amp),
    .dac_o       (dac)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic int sin_ref(input int k);
    real r;
    r = 127.0 * $sin(2.0 * 3.14159265358979 * k / 32.0);
    return int'(r);
  endfunction

  function automatic int exp_raw(input int sel, input int n);
    int p;
    case (sel)
      0: return (n % 2 == 1) ? 255 : 0;
      1: return n % 256;
      2: begin
        p = n % 510;
        return (p <= 255) ? p : 510 - p;
      end
      default: return 128 + sin_ref(n % 32);
    endcase
  endfunction

  function automatic int scale(input int raw, input int a);
    return (raw * a) >> 8;
  endfunction

  // reset with inputs applied; release on a falling edge
  task automatic do_reset(input int sel, input int lim, input int a);
    @(negedge clk);
    rst_ni    = 1'b0;
    wave_sel  = 2'(sel);
    div_limit = 24'(lim);
    amp       = 8'(a);
    repeat (2) @(negedge clk);
    check("R1 dac zero in reset", dac, 0);
    rst_ni = 1'b1;
  endtask

  // n-th advance on edge n*P, visible on dac after edge n*P+1
  task automatic run_wave(input string req, input int sel, input int lim,
                          input int a, input int nsmp);
    int per;
    per = ((lim == 0) ? 1 : lim) + 1;
    do_reset(sel, lim, a);
    @(posedge clk);
    for (int n = 1; n <= nsmp; n++) begin
      repeat (per) @(posedge clk);
      @(negedge clk);
      check(req, dac, scale(exp_raw(sel, n), a));
    end
  endtask

  task automatic test_start_values;
    do_reset(1, 5, 255);
    repeat (3) @(negedge clk);
    check("R1 ramp starts at zero", dac, 0);
    do_reset(3, 50, 255);
    repeat (3) @(negedge clk);
    check("R1 sine starts at phase 0", dac, scale(128, 255));
  endtask

  task automatic test_live_limit;
    do_reset(0, 1000, 200);
    repeat (500) @(posedge clk);
    @(negedge clk);
    check("R3 no tick before limit drop", dac, 0);
    div_limit = 24'd2;
    @(posedge clk);
    @(negedge clk);
    check("R3 raw registered one edge later", dac, 0);
    @(posedge clk);
    @(negedge clk);
    check("R3 tick on edge after drop", dac, scale(255, 200));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 new period after drop", dac, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 new period after drop", dac, scale(255, 200));
  endtask

  task automatic test_amp_live;
    do_reset(0, 1000, 255);
    repeat (1002) @(posedge clk);
    @(negedge clk);
    check("R8 full amp square high", dac, 254);
    amp = 8'd64;
    @(posedge clk);
    @(negedge clk);
    check("R8 amp change next clock", dac, scale(255, 64));
    amp = 8'd0;
    @(posedge clk);
    @(negedge clk);
    check("R8 zero amp", dac, 0);
  endtask

  task automatic test_switch;
    do_reset(1, 3, 255);
    @(posedge clk);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R9 ramp running before switch", dac, scale(10, 255));
    wave_sel = 2'd3;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 sine restarts at phase 0", dac, scale(128, 255));
    wave_sel = 2'd2;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 triangle restarts at zero", dac, 0);
    wave_sel = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 square restarts at zero", dac, 0);
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog R2: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_start_values();
    run_wave("R4 square", 0, 2, 255, 6);
    run_wave("R5 ramp wrap limit 0 R2", 1, 0, 255, 260);
    run_wave("R5 ramp half amp R8", 1, 1, 128, 20);
    run_wave("R6 triangle both turns", 2, 0, 255, 520);
    run_wave("R6 triangle period R2", 2, 5, 200, 12);
    run_wave("R7 sine two periods", 3, 1, 255, 64);
    run_wave("R7 sine quarter amp R8", 3, 3, 64, 32);
    test_live_limit();
    test_amp_live();
    test_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule